// File: doc/BRIEF.md
# Timestamp Event Capture Unit

The unit keeps a free-running 32-bit time counter and records timestamped events into a small FIFO. Event sources are a software push, counter rollover and half-rollover markers, up to four external hardware pins, and receive and transmit strobes from an Ethernet port. Each entry holds the counter value at the moment of the event and a descriptor word. The descriptor carries the event type, a port or pin number, a message type and a sequence ID.

Software drives the unit through a simple word-addressed register port. Reads are combinational, and a write takes effect on the clock edge on which `wr_en_i` is sampled high. An interrupt stays pending while the FIFO holds events. Software reads the head entry and then pops it. When several sources fire in one cycle, they are queued in a fixed priority order through one-entry pending latches per source.

Top module: `tsync_evt_unit`

## Requirements
- R1: After reset the counter is 0, the FIFO is empty, `irq_o` is 0, and control (0x04), raw status (0x20) and masked status (0x24) read 0. Identification (0x00) reads the `ID_VAL` parameter.
- R2: While control bit 0 is 1, the counter increments by one every clock. Writing 1 to bit 0 of load-enable (0x14) copies load-value (0x10) into the counter on that edge, and the load takes precedence over the increment.
- R3: Writing 1 to bit 0 of push (0x0C) records an event of type 0. Its timestamp is the counter value in the write cycle, and its other descriptor fields are zero.
- R4: When the counter increments from 0xFFFFFFFF to 0, an event of type 1 with timestamp 0 is recorded. When it increments from 0x7FFFFFFF, an event of type 2 with timestamp 0x80000000 is recorded. A load never produces either event.
- R5: Hardware pin i (0..3) passes through a two-flop synchronizer. A rising edge records an event of type 3 with pin number i+1 only if control bit 8+i is set. The timestamp is the counter value two clocks after the input rises. Falling edges record nothing.
- R6: A receive strobe records type 4 and a transmit strobe records type 5. Each carries the strobe's port, message type and sequence ID, and its timestamp is the counter value in the strobe cycle.
- R7: Events raised in the same cycle enter the FIFO one per clock in this order: software push, pins 1..4, receive, transmit, rollover, half-rollover.
- R8: The FIFO holds `DEPTH` (16) events in arrival order. Event low (0x34) reads the head timestamp. Event high (0x38) reads the head as {3'b0, port[28:24], type[23:20], message[19:16], sequence[15:0]}. Both read 0 while the FIFO is empty. Writing 1 to bit 0 of pop (0x30) discards the head, and a pop on an empty FIFO is ignored.
- R9: An event that meets a full FIFO is dropped and sets sticky overflow flag raw-status bit 1. Writing 1 to that bit clears it.
- R10: Raw-status bit 0 is 1 while the FIFO is non-empty or control bit 1 (interrupt test) is set. Masked-status bit 0 and `irq_o` equal raw bit 0 ANDed with interrupt-enable (0x28) bit 0.
- R11: While control bit 0 is 0, the counter holds its value and no event of any type is recorded.
- R12: Reserved or unaligned offsets read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i` (combinational) |
| hw_pin_i | input | 4 | Asynchronous hardware push pins |
| rx_evt_i | input | 1 | Receive event strobe |
| rx_port_i | input | 5 | Receive port number |
| rx_msg_i | input | 4 | Receive message type |
| rx_seq_i | input | 16 | Receive sequence ID |
| tx_evt_i | input | 1 | Transmit event strobe |
| tx_port_i | input | 5 | Transmit port number |
| tx_msg_i | input | 4 | Transmit message type |
| tx_seq_i | input | 16 | Transmit sequence ID |
| irq_o | output | 1 | Event interrupt |

## Verification
The bench fires a push together with receive and transmit strobes in one cycle. A design with a wrong priority order or a missing pending latch would return the entries out of order or lose one. It crosses both wrap points after a load. A design that flags the wrong transition, or stamps the pre-wrap value, gives a wrong type or timestamp. It overfills the FIFO by one entry. An overwrite on full would corrupt the oldest entries, and a missing sticky flag would leave raw bit 1 clear. It raises a disabled pin beside an enabled one, where a leaked enable shows up as an extra entry, and an early or late timestamp reveals a wrong synchronizer length.

// File: rtl/tsync_pkg.sv
package tsync_pkg;
  localparam int CNT_W = 32;

  typedef enum logic [3:0] {
    EV_PUSH = 4'd0,
    EV_ROLL = 4'd1,
    EV_HALF = 4'd2,
    EV_PIN  = 4'd3,
    EV_RX   = 4'd4,
    EV_TX   = 4'd5
  } evt_type_e;

  typedef struct packed {
    logic [CNT_W-1:0] ts;
    logic [4:0]       port;
    logic [3:0]       etype;
    logic [3:0]       msg;
    logic [15:0]      seq;
  } evt_t;

  // register word indices (byte offset / 4)
  localparam logic [5:0] W_ID    = 6'd0;
  localparam logic [5:0] W_CTRL  = 6'd1;
  localparam logic [5:0] W_PUSH  = 6'd3;
  localparam logic [5:0] W_LDVAL = 6'd4;
  localparam logic [5:0] W_LDEN  = 6'd5;
  localparam logic [5:0] W_RAW   = 6'd8;
  localparam logic [5:0] W_MSK   = 6'd9;
  localparam logic [5:0] W_IE    = 6'd10;
  localparam logic [5:0] W_POP   = 6'd12;
  localparam logic [5:0] W_LO    = 6'd13;
  localparam logic [5:0] W_HI    = 6'd14;
endpackage

// File: rtl/tsync_pin_sync.sv
module tsync_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pin_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], pin_i};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;

  assert_rise_pulse_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o);
endmodule

// File: rtl/tsync_src_arb.sv
module tsync_src_arb
  import tsync_pkg::*;
#(
  parameter int NSRC = 9
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [NSRC-1:0] fire_i,
  input  evt_t            evt_i [NSRC],
  input  logic            full_i,
  output logic            wr_o,
  output evt_t            wdata_o,
  output logic            lost_o
);
  evt_t            pend_q [NSRC];
  logic [NSRC-1:0] pv_q;
  logic [NSRC-1:0] grant;

  // lowest index wins
  always_comb begin
    grant = '0;
    for (int k = 0; k < NSRC; k++)
      if (pv_q[k] && grant == '0) grant[k] = 1'b1;
  end

  always_comb begin
    wdata_o = '0;
    for (int k = 0; k < NSRC; k++)
      if (grant[k]) wdata_o = pend_q[k];
  end

  assign wr_o   = (|grant) && !full_i;
  assign lost_o = ((|grant) && full_i) || (|(fire_i & pv_q & ~grant));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pv_q <= '0;
      for (int k = 0; k < NSRC; k++) pend_q[k] <= '0;
    end else begin
      for (int k = 0; k < NSRC; k++) begin
        if (fire_i[k] && (!pv_q[k] || grant[k])) begin
          pv_q[k]   <= 1'b1;
          pend_q[k] <= evt_i[k];
        end else if (grant[k]) begin
          pv_q[k] <= 1'b0;
        end
      end
    end
  end

  assert_one_grant_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(grant));
  assert_pend_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(pv_q & ~grant) & ~pv_q) == '0));
endmodule

// File: rtl/tsync_evt_fifo.sv
module tsync_evt_fifo
  import tsync_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_i,
  input  evt_t wdata_i,
  input  logic rd_i,
  output evt_t head_o,
  output logic empty_o,
  output logic full_o
);
  localparam int AW = $clog2(DEPTH);

  evt_t        mem [DEPTH];
  logic [AW:0] wp_q, rp_q;
  logic        wr_ok, rd_ok;

  assign empty_o = (wp_q == rp_q);
  assign full_o  = (wp_q[AW] != rp_q[AW]) && (wp_q[AW-1:0] == rp_q[AW-1:0]);
  assign wr_ok   = wr_i && !full_o;
  assign rd_ok   = rd_i && !empty_o;
  assign head_o  = empty_o ? '0 : mem[rp_q[AW-1:0]];

  always_ff @(posedge clk_i) begin
    if (wr_ok) mem[wp_q[AW-1:0]] <= wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      rp_q <= '0;
    end else begin
      if (wr_ok) wp_q <= wp_q + 1'b1;
      if (rd_ok) rp_q <= rp_q + 1'b1;
    end
  end

  assert_wr_not_full_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_i |-> !full_o);
  assert_level_bound_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wp_q - rp_q) <= (AW+1)'(DEPTH));
endmodule

// File: rtl/tsync_evt_unit.sv
module tsync_evt_unit
  import tsync_pkg::*;
#(
  parameter logic [31:0] ID_VAL      = 32'h7E51_0102,
  parameter int          DEPTH       = 16,
  parameter int          NPIN        = 4,
  parameter int          SYNC_STAGES = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        wr_en_i,
  input  logic [7:0]  addr_i,
  input  logic [31:0] wdata_i,
  output logic [31:0] rdata_o,
  input  logic [3:0]  hw_pin_i,
  input  logic        rx_evt_i,
  input  logic [4:0]  rx_port_i,
  input  logic [3:0]  rx_msg_i,
  input  logic [15:0] rx_seq_i,
  input  logic        tx_evt_i,
  input  logic [4:0]  tx_port_i,
  input  logic [3:0]  tx_msg_i,
  input  logic [15:0] tx_seq_i,
  output logic        irq_o
);
  localparam int NSRC     = NPIN + 5;
  localparam int SRC_SW   = 0;
  localparam int SRC_RX   = NPIN + 1;
  localparam int SRC_TX   = NPIN + 2;
  localparam int SRC_ROLL = NPIN + 3;
  localparam int SRC_HALF = NPIN + 4;
  localparam logic [CNT_W-1:0] ALL1 = '1;
  localparam logic [CNT_W-1:0] HALF_M1 = {1'b0, {(CNT_W-1){1'b1}}};
  localparam logic [CNT_W-1:0] HALF_V  = {1'b1, {(CNT_W-1){1'b0}}};

  logic [CNT_W-1:0] cnt_q, ldval_q;
  logic             en_q, itest_q, ie_q, ovf_q;
  logic [NPIN-1:0]  pen_q, rise;
  logic [5:0]       word;
  logic             aligned;
  logic             wr_ctrl, wr_push, wr_ldval, wr_ldld, wr_raw, wr_ie, wr_pop;
  logic             load, raw0;
  logic [NSRC-1:0]  fire;
  evt_t             src_evt [NSRC];
  evt_t             fifo_wdata, head;
  logic             fifo_wr, fifo_empty, fifo_full, lost;

  assign word     = addr_i[7:2];
  assign aligned  = (addr_i[1:0] == 2'b00);
  assign wr_ctrl  = wr_en_i && aligned && word == W_CTRL;
  assign wr_push  = wr_en_i && aligned && word == W_PUSH  && wdata_i[0];
  assign wr_ldval = wr_en_i && aligned && word == W_LDVAL;
  assign wr_ldld  = wr_en_i && aligned && word == W_LDEN  && wdata_i[0];
  assign wr_raw   = wr_en_i && aligned && word == W_RAW;
  assign wr_ie    = wr_en_i && aligned && word == W_IE;
  assign wr_pop   = wr_en_i && aligned && word == W_POP   && wdata_i[0];
  assign load     = wr_ldld;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ldval_q <= '0;
      en_q    <= 1'b0;
      itest_q <= 1'b0;
      pen_q   <= '0;
      ie_q    <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      if (load)      cnt_q <= ldval_q;
      else if (en_q) cnt_q <= cnt_q + 1'b1;
      if (wr_ldval)  ldval_q <= wdata_i;
      if (wr_ctrl) begin
        en_q    <= wdata_i[0];
        itest_q <= wdata_i[1];
        pen_q   <= wdata_i[8 +: NPIN];
      end
      if (wr_ie) ie_q <= wdata_i[0];
      if (lost)                     ovf_q <= 1'b1;
      else if (wr_raw && wdata_i[1]) ovf_q <= 1'b0;
    end
  end

  // event sources
  always_comb begin
    src_evt[SRC_SW]   = '{ts: cnt_q, port: 5'd0, etype: EV_PUSH, msg: 4'd0, seq: 16'd0};
    src_evt[SRC_RX]   = '{ts: cnt_q, port: rx_port_i, etype: EV_RX, msg: rx_msg_i, seq: rx_seq_i};
    src_evt[SRC_TX]   = '{ts: cnt_q, port: tx_port_i, etype: EV_TX, msg: tx_msg_i, seq: tx_seq_i};
    src_evt[SRC_ROLL] = '{ts: '0, port: 5'd0, etype: EV_ROLL, msg: 4'd0, seq: 16'd0};
    src_evt[SRC_HALF] = '{ts: HALF_V, port: 5'd0, etype: EV_HALF, msg: 4'd0, seq: 16'd0};
    fire[SRC_SW]      = en_q && wr_push;
    fire[SRC_RX]      = en_q && rx_evt_i;
    fire[SRC_TX]      = en_q && tx_evt_i;
    fire[SRC_ROLL]    = en_q && !load && cnt_q == ALL1;
    fire[SRC_HALF]    = en_q && !load && cnt_q == HALF_M1;
    for (int i = 0; i < NPIN; i++) begin
      src_evt[1+i] = '{ts: cnt_q, port: 5'(i+1), etype: EV_PIN, msg: 4'd0, seq: 16'd0};
      fire[1+i]    = en_q && pen_q[i] && rise[i];
    end
  end

  for (genvar g = 0; g < NPIN; g++) begin : g_pin
    tsync_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .pin_i  (hw_pin_i[g]),
      .rise_o (rise[g])
    );
  end

  tsync_src_arb #(.NSRC(NSRC)) u_arb (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .fire_i  (fire),
    .evt_i   (src_evt),
    .full_i  (fifo_full),
    .wr_o    (fifo_wr),
    .wdata_o (fifo_wdata),
    .lost_o  (lost)
  );

  tsync_evt_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (fifo_wr),
    .wdata_i (fifo_wdata),
    .rd_i    (wr_pop),
    .head_o  (head),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  assign raw0  = !fifo_empty || itest_q;
  assign irq_o = raw0 && ie_q;

  always_comb begin
    rdata_o = '0;
    if (aligned) begin
      case (word)
        W_ID:    rdata_o = ID_VAL;
        W_CTRL: begin
          rdata_o[0]         = en_q;
          rdata_o[1]         = itest_q;
          rdata_o[8 +: NPIN] = pen_q;
        end
        W_LDVAL: rdata_o = ldval_q;
        W_RAW:   rdata_o = {30'd0, ovf_q, raw0};
        W_MSK:   rdata_o = {31'd0, irq_o};
        W_IE:    rdata_o = {31'd0, ie_q};
        W_LO:    rdata_o = head.ts;
        W_HI:    rdata_o = {3'd0, head.port, head.etype, head.msg, head.seq};
        default: rdata_o = '0;
      endcase
    end
  end

  assert_cnt_inc_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_q && !load) |=> cnt_q == $past(cnt_q) + 1'b1);
  assert_cnt_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !load) |=> $stable(cnt_q));
  assert_irq_on_write_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_wr && ie_q && !wr_ie) |=> irq_o);
  assert_no_event_off_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> fire == '0);
endmodule

// File: tb/tb_tsync_evt_unit.sv
`timescale 1ns/1ps
module tb_tsync_evt_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic [3:0]  pins = '0;
  logic        rx_evt = 1'b0, tx_evt = 1'b0;
  logic [4:0]  rx_port = '0, tx_port = '0;
  logic [3:0]  rx_msg = '0, tx_msg = '0;
  logic [15:0] rx_seq = '0, tx_seq = '0;
  logic        irq;

  localparam logic [31:0] ID = 32'h7E51_0102;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  logic [63:0] exp_q[$];
  string       tag_q[$];

  // bench-side counter model
  logic [31:0] m_cnt, m_ld;
  logic        m_en;

  always #4 clk = ~clk;

  tsync_evt_unit #(.ID_VAL(ID)) dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr), .wdata_i(wdata),
    .rdata_o(rdata), .hw_pin_i(pins),
    .rx_evt_i(rx_evt), .rx_port_i(rx_port), .rx_msg_i(rx_msg), .rx_seq_i(rx_seq),
    .tx_evt_i(tx_evt), .tx_port_i(tx_port), .tx_msg_i(tx_msg), .tx_seq_i(tx_seq),
    .irq_o(irq)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt <= '0; m_ld <= '0; m_en <= 1'b0;
    end else begin
      if (wr_en && addr == 8'h04) m_en <= wdata[0];
      if (wr_en && addr == 8'h10) m_ld <= wdata;
      if (wr_en && addr == 8'h14 && wdata[0]) m_cnt <= m_ld;
      else if (m_en) m_cnt <= m_cnt + 1;
    end
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d, output logic [31:0] ts);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d; ts = m_cnt;
    @(negedge clk);
    wr_en = 1'b0; addr = '0; wdata = '0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    logic [31:0] unused_ts;
    bus_wr(a, d, unused_ts);
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
    addr = '0;
  endtask

  task automatic expect_evt(input string tag, input logic [31:0] lo, input logic [31:0] hi);
    exp_q.push_back({hi, lo});
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pop design results and compare against the scoreboard
  task automatic drain();
    logic [31:0] lo, hi, raw;
    while (exp_q.size() > 0) begin
      bus_rd(8'h34, lo);
      bus_rd(8'h38, hi);
      check({tag_q[0], " ts"}, lo, exp_q[0][31:0]);
      check({tag_q[0], " desc"}, hi, exp_q[0][63:32]);
      void'(exp_q.pop_front());
      void'(tag_q.pop_front());
      wr(8'h30, 32'h1);
    end
    bus_rd(8'h20, raw);
    check("R8 empty after drain", raw & 32'h1, 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, t;
    idle(3);
    rst_n = 1'b1;
    idle(2);

    // R1 reset state
    bus_rd(8'h00, d); check("R1 id", d, ID);
    bus_rd(8'h04, d); check("R1 ctrl", d, 0);
    bus_rd(8'h20, d); check("R1 raw", d, 0);
    bus_rd(8'h24, d); check("R1 masked", d, 0);
    check("R1 irq", {31'd0, irq}, 0);
    bus_rd(8'h34, d); check("R8 lo empty", d, 0);
    bus_rd(8'h38, d); check("R8 hi empty", d, 0);

    // R11 disabled: push ignored
    wr(8'h0C, 32'h1);
    idle(3);
    bus_rd(8'h20, d); check("R11 no event while off", d, 0);

    // R12 reserved offsets
    wr(8'h08, 32'hFFFF_FFFF);
    wr(8'h05, 32'hFFFF_FFFF);
    bus_rd(8'h08, d); check("R12 reserved read", d, 0);
    bus_rd(8'h04, d); check("R12 ctrl untouched", d, 0);

    // R8 pop on empty ignored
    wr(8'h30, 32'h1);

    // R2/R3 enable, load, push
    wr(8'h28, 32'h1);
    wr(8'h04, 32'h1);
    wr(8'h10, 32'h0000_1000);
    wr(8'h14, 32'h1);
    bus_wr(8'h0C, 32'h1, t);
    expect_evt("R3 push after load R2", t, 32'h0);
    idle(2);
    check("R10 irq on event", {31'd0, irq}, 1);
    drain();
    check("R10 irq cleared", {31'd0, irq}, 0);

    // R11 pause then resume: counter held
    wr(8'h04, 32'h0);
    idle(5);
    wr(8'h04, 32'h1);
    bus_wr(8'h0C, 32'h1, t);
    expect_evt("R11 held counter", t, 32'h0);
    idle(3);
    drain();

    // R6 receive and transmit
    @(negedge clk);
    rx_evt = 1; rx_port = 5'd3; rx_msg = 4'hB; rx_seq = 16'h1234; t = m_cnt;
    @(negedge clk); rx_evt = 0;
    expect_evt("R6 rx", t, 32'h034B_1234);
    @(negedge clk);
    tx_evt = 1; tx_port = 5'd7; tx_msg = 4'h2; tx_seq = 16'hBEEF; t = m_cnt;
    @(negedge clk); tx_evt = 0;
    expect_evt("R6 tx", t, 32'h0752_BEEF);
    idle(3);
    drain();

    // R7 simultaneous push, rx, tx
    @(negedge clk);
    wr_en = 1; addr = 8'h0C; wdata = 32'h1;
    rx_evt = 1; rx_port = 5'd1; rx_msg = 4'h1; rx_seq = 16'h0001;
    tx_evt = 1; tx_port = 5'd2; tx_msg = 4'h3; tx_seq = 16'h0002;
    t = m_cnt;
    @(negedge clk);
    wr_en = 0; addr = '0; wdata = '0; rx_evt = 0; tx_evt = 0;
    expect_evt("R7 first push", t, 32'h0);
    expect_evt("R7 second rx", t, 32'h0141_0001);
    expect_evt("R7 third tx", t, 32'h0253_0002);
    idle(5);
    drain();

    // R5 pins: pin 1 enabled, pin 2 disabled
    wr(8'h04, 32'h0000_0101);
    @(negedge clk);
    pins = 4'b0011; t = m_cnt + 2;
    expect_evt("R5 pin1 rise", t, 32'h0130_0000);
    idle(6);
    pins = 4'b0000;
    idle(6);
    drain();

    // R4 rollover and half rollover
    wr(8'h10, 32'hFFFF_FFFD);
    wr(8'h14, 32'h1);
    expect_evt("R4 rollover", 32'h0, 32'h0010_0000);
    idle(6);
    drain();
    wr(8'h10, 32'h7FFF_FFFE);
    wr(8'h14, 32'h1);
    expect_evt("R4 half rollover", 32'h8000_0000, 32'h0020_0000);
    idle(6);
    drain();

    // R9 overfill by one
    for (int i = 0; i < 17; i++) begin
      bus_wr(8'h0C, 32'h1, t);
      if (i < 16) expect_evt($sformatf("R9 fifo order %0d", i), t, 32'h0);
    end
    idle(4);
    bus_rd(8'h20, d); check("R9 overflow flag", d, 32'h3);
    drain();
    bus_rd(8'h20, d); check("R9 flag sticky", d, 32'h2);
    wr(8'h20, 32'h2);
    bus_rd(8'h20, d); check("R9 flag cleared", d, 0);

    // R10 interrupt test and mask
    wr(8'h04, 32'h3);
    bus_rd(8'h20, d); check("R10 test raw", d, 32'h1);
    check("R10 test irq", {31'd0, irq}, 1);
    wr(8'h28, 32'h0);
    bus_rd(8'h24, d); check("R10 masked off", d, 0);
    check("R10 irq masked", {31'd0, irq}, 0);
    wr(8'h04, 32'h1);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule